// File: doc/BRIEF.md
# Wired Interrupt Source Gateway Array

This block keeps the per-source state of a bank of wired interrupt lines. Sources are numbered 1 to `NUM_SRC`; index 0 is never implemented. Every source holds a trigger mode, a stored copy of its last sampled input, a pending flag and an enable flag. Each raw input level passes through a two-flop synchroniser. The configured mode then turns the synchronised level into pending requests.

A register front end, which lies outside this block, reaches the array through three paths. A configuration write port sets a source's mode. A command port sets or clears pending and enable for one indexed source. A combinational read port returns mode, pending, enable and input for one indexed source. A delivery stage sees the pending and enable vectors and retires a request by pulsing that source's bit on a clear vector.

Top module: `irq_gateway_array`

## Requirements
- R1: After reset every source has mode inactive (code 0) and its pending, enable and input bits at 0. The read port returns all zero for every index.
- R2: In rising mode (code 4), pending becomes 1 on a cycle where the synchronised level is 1 and the stored input is 0.
- R3: In falling mode (code 5), pending becomes 1 on a cycle where the synchronised level is 0 and the stored input is 1.
- R4: In level-high mode (code 6), pending is forced to 1 on every cycle the synchronised level is 1. Level-low mode (code 7) does the same on every cycle the level is 0.
- R5: In every mode except detached, the stored input bit takes the synchronised level on every clock. A change on a raw input reaches the stored input bit and pending at the third rising edge after the change.
- R6: In detached mode (code 1), the input is ignored completely: the stored input bit holds and the gateway never sets pending. The mode field reads back as 0.
- R7: A command with op 1 (clear pending) has no effect on a source in either level mode and clears pending in every other mode. A command with op 0 (set pending) sets pending in all modes.
- R8: Commands, configuration writes and reads that name index 0, or any index above `NUM_SRC`, change no state. Such reads return zero in every field.
- R9: When a set of pending (from the gateway or from op 0) and a delivery clear hit the same source in the same cycle, pending ends at 1. A delivery clear on its own clears pending.
- R10: Op 2 sets and op 3 clears the enable bit of the indexed source only. The enable vector output reflects the result one clock later.
- R11: Writing mode codes 2 or 3 stores inactive (code 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_level_i | input | NUM_SRC | Raw source levels; bit k is source k+1 |
| cfg_we_i | input | 1 | Mode write strobe |
| cfg_idx_i | input | IDX_W | Source index for the mode write |
| cfg_mode_i | input | 3 | Mode code to write |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | 0 set pending, 1 clear pending, 2 set enable, 3 clear enable |
| cmd_idx_i | input | IDX_W | Source index for the command |
| dlv_clr_i | input | NUM_SRC | Delivery clear of pending; bit k is source k+1 |
| rd_idx_i | input | IDX_W | Source index to read |
| rd_mode_o | output | 3 | Mode of the read source (0 if detached) |
| rd_pend_o | output | 1 | Pending bit of the read source |
| rd_en_o | output | 1 | Enable bit of the read source |
| rd_in_o | output | 1 | Stored input bit of the read source |
| pending_o | output | NUM_SRC | Pending vector |
| enable_o | output | NUM_SRC | Enable vector |

## Verification
Configuration writes, commands and delivery clears act at the first rising edge after they are presented. A raw level change acts at the third edge, because of the two synchroniser stages and the state register. The read port is combinational on the current state. The bench drives its stimulus one nanosecond after an edge and samples one nanosecond after the edge where a result is due. After every level change it waits four edges, so the steady result, including a single edge event, is in place before it is read. Each source is swept through every mode and a fixed level sequence. The expected pending and input values come from a per-source model that applies the trigger rules, and the pending vector is compared so that other sources are seen to stay untouched.

// File: rtl/gw_pkg.sv
package gw_pkg;

  typedef enum logic [2:0] {
    MODE_OFF    = 3'd0,
    MODE_DETACH = 3'd1,
    MODE_RISE   = 3'd4,
    MODE_FALL   = 3'd5,
    MODE_HIGH   = 3'd6,
    MODE_LOW    = 3'd7
  } gw_mode_e;

  typedef enum logic [1:0] {
    OP_SET_PEND = 2'd0,
    OP_CLR_PEND = 2'd1,
    OP_SET_EN   = 2'd2,
    OP_CLR_EN   = 2'd3
  } gw_op_e;

  // Reserved codes collapse to inactive
  function automatic gw_mode_e legalize(input logic [2:0] raw);
    gw_mode_e m;
    case (raw)
      3'd1:    m = MODE_DETACH;
      3'd4:    m = MODE_RISE;
      3'd5:    m = MODE_FALL;
      3'd6:    m = MODE_HIGH;
      3'd7:    m = MODE_LOW;
      default: m = MODE_OFF;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/gw_sync.sv
module gw_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;

endmodule

// File: rtl/gw_cell.sv
module gw_cell
  import gw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl_i,
  input  logic       cfg_we_i,
  input  logic [2:0] cfg_mode_i,
  input  logic       sw_set_pend_i,
  input  logic       sw_clr_pend_i,
  input  logic       sw_set_en_i,
  input  logic       sw_clr_en_i,
  input  logic       dlv_clr_i,
  output logic [2:0] mode_o,
  output logic       pend_o,
  output logic       en_o,
  output logic       in_o
);

  gw_mode_e mode_q, mode_d;
  logic     in_q, in_d;
  logic     pend_q, pend_d;
  logic     en_q, en_d;
  logic     is_det, is_lvl, gw_hit, clr_any;

  always_comb begin
    mode_d = legalize(cfg_mode_i);
    is_det = (mode_q == MODE_DETACH);
    is_lvl = (mode_q == MODE_HIGH) || (mode_q == MODE_LOW);
    case (mode_q)
      MODE_RISE: gw_hit = lvl_i & ~in_q;
      MODE_FALL: gw_hit = ~lvl_i & in_q;
      MODE_HIGH: gw_hit = lvl_i;
      MODE_LOW:  gw_hit = ~lvl_i;
      default:   gw_hit = 1'b0;
    endcase
    clr_any = dlv_clr_i | (sw_clr_pend_i & ~is_lvl);
    pend_d  = (pend_q & ~clr_any) | gw_hit | sw_set_pend_i;
    in_d    = is_det ? in_q : lvl_i;
    en_d    = (en_q & ~sw_clr_en_i) | sw_set_en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_OFF;
      in_q   <= 1'b0;
      pend_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      if (cfg_we_i) mode_q <= mode_d;
      in_q   <= in_d;
      pend_q <= pend_d;
      en_q   <= en_d;
    end
  end

  assign mode_o = mode_q;
  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign in_o   = in_q;

  assert_rise_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_RISE && lvl_i && !in_q) |=> pend_q);

  assert_fall_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_FALL && !lvl_i && in_q) |=> pend_q);

  assert_level_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MODE_HIGH && lvl_i) || (mode_q == MODE_LOW && !lvl_i)) |=> pend_q);

  assert_input_tracks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MODE_DETACH) |=> (in_q == $past(lvl_i)));

  assert_detach_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_DETACH && !cfg_we_i) |=> ($stable(in_q) && $stable(mode_q)));

  assert_lvl_clear_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MODE_HIGH || mode_q == MODE_LOW) && sw_clr_pend_i && !dlv_clr_i && pend_q)
      |=> pend_q);

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_set_pend_i && dlv_clr_i) |=> pend_q);

  assert_enable_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sw_set_en_i |=> en_q);

endmodule

// File: rtl/irq_gateway_array.sv
module irq_gateway_array
  import gw_pkg::*;
#(
  parameter  int NUM_SRC = 32,
  localparam int IDX_W   = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_level_i,
  input  logic               cfg_we_i,
  input  logic [IDX_W-1:0]   cfg_idx_i,
  input  logic [2:0]         cfg_mode_i,
  input  logic               cmd_valid_i,
  input  logic [1:0]         cmd_op_i,
  input  logic [IDX_W-1:0]   cmd_idx_i,
  input  logic [NUM_SRC-1:0] dlv_clr_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic [2:0]         rd_mode_o,
  output logic               rd_pend_o,
  output logic               rd_en_o,
  output logic               rd_in_o,
  output logic [NUM_SRC-1:0] pending_o,
  output logic [NUM_SRC-1:0] enable_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SRC);

  logic [NUM_SRC-1:0] lvl_s;
  logic [NUM_SRC-1:0] cfg_hit, cmd_hit, in_vec;
  logic [2:0]         mode_vec [NUM_SRC];
  gw_op_e             op;
  logic               cmd_idx_ok, rd_idx_ok;

  assign op         = gw_op_e'(cmd_op_i);
  assign cmd_idx_ok = (cmd_idx_i != '0) && (cmd_idx_i <= LAST_IDX);
  assign rd_idx_ok  = (rd_idx_i  != '0) && (rd_idx_i  <= LAST_IDX);

  gw_sync #(.W(NUM_SRC)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (src_level_i),
    .q_o   (lvl_s)
  );

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    assign cfg_hit[k] = cfg_we_i    && (cfg_idx_i == IDX_W'(k + 1));
    assign cmd_hit[k] = cmd_valid_i && (cmd_idx_i == IDX_W'(k + 1));

    gw_cell u_cell (
      .clk           (clk),
      .rst_n         (rst_n),
      .lvl_i         (lvl_s[k]),
      .cfg_we_i      (cfg_hit[k]),
      .cfg_mode_i    (cfg_mode_i),
      .sw_set_pend_i (cmd_hit[k] && op == OP_SET_PEND),
      .sw_clr_pend_i (cmd_hit[k] && op == OP_CLR_PEND),
      .sw_set_en_i   (cmd_hit[k] && op == OP_SET_EN),
      .sw_clr_en_i   (cmd_hit[k] && op == OP_CLR_EN),
      .dlv_clr_i     (dlv_clr_i[k]),
      .mode_o        (mode_vec[k]),
      .pend_o        (pending_o[k]),
      .en_o          (enable_o[k]),
      .in_o          (in_vec[k])
    );
  end

  always_comb begin
    rd_mode_o = '0;
    rd_pend_o = 1'b0;
    rd_en_o   = 1'b0;
    rd_in_o   = 1'b0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (rd_idx_i == IDX_W'(k + 1)) begin
        rd_mode_o = (mode_vec[k] == 3'(MODE_DETACH)) ? 3'd0 : mode_vec[k];
        rd_pend_o = pending_o[k];
        rd_en_o   = enable_o[k];
        rd_in_o   = in_vec[k];
      end
    end
  end

  assert_bad_cmd_index_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && !cmd_idx_ok) |-> (cmd_hit == '0));

  assert_bad_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_idx_ok |-> (rd_mode_o == '0 && !rd_pend_o && !rd_en_o && !rd_in_o));

  assert_single_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_hit) && $onehot0(cfg_hit));

endmodule

// File: tb/irq_gateway_array_bench.sv
`timescale 1ns/1ps
module irq_gateway_array_bench;

  localparam int N  = 5;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  lvl;
  logic          cfg_we;
  logic [IW-1:0] cfg_idx;
  logic [2:0]    cfg_mode;
  logic          cmd_valid;
  logic [1:0]    cmd_op;
  logic [IW-1:0] cmd_idx;
  logic [N-1:0]  dlv_clr;
  logic [IW-1:0] rd_idx;
  logic [2:0]    rd_mode;
  logic          rd_pend, rd_en, rd_in;
  logic [N-1:0]  pending, enable;

  int  checks   = 0;
  int  failures = 0;
  bit  done     = 1'b0;

  always #2 clk = ~clk;

  irq_gateway_array #(.NUM_SRC(N)) u_irq_gateway_array (
    .clk(clk), .rst_n(rst_n), .src_level_i(lvl),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_mode_i(cfg_mode),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_idx_i(cmd_idx),
    .dlv_clr_i(dlv_clr), .rd_idx_i(rd_idx),
    .rd_mode_o(rd_mode), .rd_pend_o(rd_pend), .rd_en_o(rd_en), .rd_in_o(rd_in),
    .pending_o(pending), .enable_o(enable)
  );

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic rd(input int idx);
    rd_idx = IW'(idx);
    #0.1;
  endtask

  task automatic cfg(input int idx, input int m);
    cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_mode = 3'(m);
    tick(1);
    cfg_we = 1'b0;
  endtask

  task automatic cmd(input int op, input int idx);
    cmd_valid = 1'b1; cmd_op = 2'(op); cmd_idx = IW'(idx);
    tick(1);
    cmd_valid = 1'b0;
  endtask

  function automatic int mode_readback(input int m);
    return (m == 1 || m == 2 || m == 3) ? 0 : m;
  endfunction

  function automatic string mode_tag(input int m);
    case (m)
      1: return "R6";
      4: return "R2";
      5: return "R3";
      6, 7: return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired got=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int modes [6] = '{0, 1, 4, 5, 6, 7};
    int seq   [6] = '{1, 1, 0, 0, 1, 0};
    rst_n = 1'b0; lvl = '0; cfg_we = 0; cfg_idx = '0; cfg_mode = '0;
    cmd_valid = 0; cmd_op = '0; cmd_idx = '0; dlv_clr = '0; rd_idx = '0;
    tick(3);
    rst_n = 1'b1;
    tick(2);

    // R1: reset state
    chk("R1 pending vector", 32'(pending), 0);
    chk("R1 enable vector", 32'(enable), 0);
    for (int s = 0; s <= 7; s++) begin
      rd(s);
      chk("R1 read fields", {rd_mode, rd_pend, rd_en, rd_in}, 0);
    end

    // Sweep every source through every mode (R2..R7)
    for (int s = 1; s <= N; s++) begin
      for (int mi = 0; mi < 6; mi++) begin
        int m = modes[mi];
        logic ep, ei;
        cfg(s, 0);
        lvl[s-1] = 1'b0;
        tick(4);
        cmd(1, s);
        cfg(s, m);
        tick(2);
        rd(s);
        chk("R6 mode readback", 32'(rd_mode), 32'(mode_readback(m)));
        ep = (m == 7);
        ei = 1'b0;
        chk("R4 initial pend", 32'(rd_pend), 32'(ep));
        for (int st = 0; st < 6; st++) begin
          logic v = seq[st][0];
          lvl[s-1] = v;
          tick(4);
          if (m != 1) begin
            if ((m == 4 && v && !ei) || (m == 5 && !v && ei) ||
                (m == 6 && v) || (m == 7 && !v)) ep = 1'b1;
            ei = v;
          end
          rd(s);
          chk({mode_tag(m), " pend after level step"}, 32'(rd_pend), 32'(ep));
          chk({(m == 1) ? "R6" : "R5", " stored input"}, 32'(rd_in), 32'(ei));
          chk("R8 other sources untouched", 32'(pending), 32'(ep) << (s - 1));
          // R7: software clear
          cmd(1, s);
          if (!(m == 6 || m == 7)) ep = 1'b0;
          rd(s);
          chk("R7 software clear", 32'(rd_pend), 32'(ep));
        end
        cmd(0, s);
        rd(s);
        chk("R7 software set", 32'(rd_pend), 1);
        cfg(s, 0);
        lvl[s-1] = 1'b0;
        tick(4);
        cmd(1, s);
        rd(s);
        chk("R7 clear in inactive", 32'(rd_pend), 0);
      end
    end

    // R11: reserved codes
    cfg(2, 2); rd(2); chk("R11 code 2 stored inactive", 32'(rd_mode), 0);
    cfg(2, 5); cfg(2, 3); rd(2); chk("R11 code 3 stored inactive", 32'(rd_mode), 0);

    // R10: enable set/clear
    cmd(2, 3);
    chk("R10 enable one", 32'(enable), 32'b00100);
    for (int s = 1; s <= N; s++) cmd(2, s);
    chk("R10 enable all", 32'(enable), 32'b11111);
    cmd(3, 4);
    chk("R10 clear one", 32'(enable), 32'b10111);
    rd(4); chk("R10 read enable", 32'(rd_en), 0);
    for (int s = 1; s <= N; s++) cmd(3, s);
    chk("R10 clear all", 32'(enable), 0);

    // R8: bad indices
    cmd(0, 0); cmd(0, 6); cmd(0, 7);
    chk("R8 bad set pend", 32'(pending), 0);
    cmd(2, 0); cmd(2, 6); cmd(2, 7);
    chk("R8 bad set enable", 32'(enable), 0);
    cfg(0, 4); cfg(6, 4); cfg(7, 6);
    for (int s = 1; s <= N; s++) begin
      rd(s); chk("R8 bad cfg write", 32'(rd_mode), 0);
    end
    lvl = '1;
    for (int s = 1; s <= N; s++) cmd(0, s);
    tick(4);
    foreach (seq[i]) if (i < 3) begin
      int bad = (i == 0) ? 0 : (i == 1) ? 6 : 7;
      rd(bad);
      chk("R8 bad read zero", {rd_mode, rd_pend, rd_en, rd_in}, 0);
    end
    for (int s = 1; s <= N; s++) cmd(1, s);
    lvl = '0;
    tick(4);

    // R9: set beats delivery clear
    cfg(1, 4);
    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_idx = 3'd1; dlv_clr = 5'b00001;
    tick(1);
    cmd_valid = 1'b0; dlv_clr = '0;
    rd(1); chk("R9 sw set wins", 32'(rd_pend), 1);
    dlv_clr = 5'b00001; tick(1); dlv_clr = '0;
    rd(1); chk("R9 delivery clear alone", 32'(rd_pend), 0);
    cfg(1, 6);
    lvl[0] = 1'b1;
    dlv_clr = 5'b00001;
    tick(4);
    rd(1); chk("R9 level set wins", 32'(rd_pend), 1);
    lvl[0] = 1'b0;
    tick(4);
    rd(1); chk("R9 clear once level drops", 32'(rd_pend), 0);
    dlv_clr = '0;
    tick(1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule